// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Threshold Flags

This block is the level-tracking and threshold-flag section of one synchronous FIFO. It follows the accepted writes and reads of the queue, keeps the occupancy count, and drives four registered status outputs: empty, full, almost-empty and almost-full. Each of the two "almost" flags is compared against its own offset register. The storage array is outside this block. Write and read accept decisions are made here, so that a surrounding FIFO can gate its array strobes from the same conditions.

The offsets are set up at master reset in one of two ways. Either a two-bit preset selector picks one of three built-in values, which are then applied to both offsets. Or the selector picks user programming, and a mode input chooses how the offsets are loaded. In the serial method they are shifted in one bit per clock. In the parallel method they are taken from the first two words presented on the write data port. A partial reset empties the queue but leaves the offsets and the programming state untouched.

Both flags are registered on the single FIFO clock. They therefore change only on a clock edge and always describe the occupancy that results from that edge.

Top module: `fifo_level_flags`

## Requirements
- R1: `almost_empty` is 1 exactly when the occupancy count after the most recent clock edge is less than or equal to the almost-empty offset. It is registered, so it changes only on a clock edge.
- R2: `almost_full` is 1 exactly when the free space (DEPTH minus occupancy) after the most recent edge is less than or equal to the almost-full offset. It is registered in the same way.
- R3: `empty` is 1 when the occupancy is 0, and `full` is 1 when the occupancy equals DEPTH. A write while full and a read while empty are ignored and leave the occupancy unchanged.
- R4: A clock edge with `mrst`=1 clears the occupancy and samples `preset_sel`. The value 2'b01 loads both offsets with 8, 2'b10 loads 16 and 2'b11 loads 64, and writes are accepted from the next edge on.
- R5: With `preset_sel`=2'b00 and `serial_sel`=1 at master reset, both offsets start at 0. Each edge with `ser_en`=1 shifts in `ser_bit`: the first OFS_W bits fill the almost-empty offset LSB first, and the next OFS_W bits fill the almost-full offset LSB first. After those 2*OFS_W bits, further `ser_en` pulses are ignored. Writes are ignored until loading is complete.
- R6: With `preset_sel`=2'b00 and `serial_sel`=0 at master reset, the first accepted `wr_en` loads `wr_data[OFS_W-1:0]` into the almost-empty offset and the second loads it into the almost-full offset. Neither of these two writes changes the occupancy. Later writes enter the FIFO.
- R7: An edge with `prst`=1 and `mrst`=0 clears the occupancy to 0. It keeps both offsets and the programming progress, and it ignores load and data inputs in that cycle. `mrst` takes priority over `prst`.
- R8: An accepted write and an accepted read on the same edge leave the occupancy unchanged. A write on a full FIFO is dropped while a read in the same cycle is still taken, and a read on an empty FIFO is dropped while a write in the same cycle is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| preset_sel | input | 2 | Offset preset choice sampled at master reset (00 = user programming) |
| serial_sel | input | 1 | User programming method sampled at master reset (1 = serial, 0 = parallel) |
| ser_en | input | 1 | Serial load enable |
| ser_bit | input | 1 | Serial load data bit |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data; its low OFS_W bits are used for parallel offset loads |
| rd_en | input | 1 | Read request |
| almost_empty | output | 1 | Occupancy at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
The two functions that share a cycle most often are the write path and the read path. A write and a read can be accepted on the same edge, including right at the empty boundary, the full boundary and a threshold boundary. The bench holds the count at exactly the almost-empty offset while it issues paired writes and reads, then adds one write, and judges from the flag that the count did not drift. A second overlap is partial reset against offset loading and data writes. The bench checks that both offsets and the parallel-load progress survive by probing each flag threshold afterwards, while a cycle-by-cycle behavioural model is compared against all four outputs on every clock.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

   typedef enum logic [1:0] {
      PRESET_USER = 2'b00,
      PRESET_LO   = 2'b01,
      PRESET_MID  = 2'b10,
      PRESET_HI   = 2'b11
   } preset_e;

   localparam int FLAG_AE = 0;
   localparam int FLAG_AF = 1;
   localparam int FLAG_N  = 2;

endpackage

// File: rtl/fifo_ofs_regs.sv
module fifo_ofs_regs
   import fifo_flag_pkg::*;
#(
   parameter int OFS_W   = 8,
   parameter int DEF_LO  = 8,
   parameter int DEF_MID = 16,
   parameter int DEF_HI  = 64
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             prst,
   input  logic [1:0]       preset_sel,
   input  logic             serial_sel,
   input  logic             ser_en,
   input  logic             ser_bit,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] wr_low,
   output logic [OFS_W-1:0] ae_ofs_nx,
   output logic [OFS_W-1:0] af_ofs_nx,
   output logic             cfg_done
);

   localparam int SH_W = 2 * OFS_W;
   localparam int BC_W = $clog2(SH_W + 1);
   localparam logic [BC_W-1:0]  BC_LAST = BC_W'(SH_W - 1);
   localparam logic [OFS_W-1:0] D_LO    = OFS_W'(DEF_LO);
   localparam logic [OFS_W-1:0] D_MID   = OFS_W'(DEF_MID);
   localparam logic [OFS_W-1:0] D_HI    = OFS_W'(DEF_HI);

   logic [SH_W-1:0] sh_q, sh_nx;
   logic [BC_W-1:0] bc_q, bc_nx;
   logic            pc_q, pc_nx;
   logic            done_q, done_nx;
   logic            ser_q, ser_nx;

   always_comb begin
      sh_nx   = sh_q;
      bc_nx   = bc_q;
      pc_nx   = pc_q;
      done_nx = done_q;
      ser_nx  = ser_q;
      if (mrst) begin
         ser_nx = serial_sel;
         bc_nx  = '0;
         pc_nx  = 1'b0;
         unique case (preset_e'(preset_sel))
            PRESET_LO:   begin sh_nx = {D_LO,  D_LO};  done_nx = 1'b1; end
            PRESET_MID:  begin sh_nx = {D_MID, D_MID}; done_nx = 1'b1; end
            PRESET_HI:   begin sh_nx = {D_HI,  D_HI};  done_nx = 1'b1; end
            default:     begin sh_nx = '0;             done_nx = 1'b0; end
         endcase
      end else if (!prst && !done_q) begin
         if (ser_q) begin
            if (ser_en) begin
               sh_nx = {ser_bit, sh_q[SH_W-1:1]};
               bc_nx = bc_q + 1'b1;
               if (bc_q == BC_LAST) done_nx = 1'b1;
            end
         end else if (wr_en) begin
            if (!pc_q) begin
               sh_nx[OFS_W-1:0] = wr_low;
               pc_nx            = 1'b1;
            end else begin
               sh_nx[SH_W-1:OFS_W] = wr_low;
               done_nx             = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      sh_q   <= sh_nx;
      bc_q   <= bc_nx;
      pc_q   <= pc_nx;
      done_q <= done_nx;
      ser_q  <= ser_nx;
   end

   assign ae_ofs_nx = sh_nx[OFS_W-1:0];
   assign af_ofs_nx = sh_nx[SH_W-1:OFS_W];
   assign cfg_done  = done_q;

   // R7: partial reset keeps offsets and programming progress
   p_prst_keeps_ofs_r7: assert property (@(posedge clk) disable iff (mrst)
      prst |=> $stable(sh_q) && $stable(done_q) && $stable(pc_q));

   // R5 / R6: once loaded, offsets are frozen until the next master reset
   p_done_frozen_r5: assert property (@(posedge clk) disable iff (mrst)
      done_q |=> done_q && $stable(sh_q));

   // R6: a parallel load never consumes more than two words
   p_par_two_words_r6: assert property (@(posedge clk) disable iff (mrst)
      (!ser_q && pc_q && wr_en && !prst && !done_q) |=> done_q);

endmodule

// File: rtl/fifo_occ_counter.sv
module fifo_occ_counter #(
   parameter int DEPTH = 256,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             wr_req,
   input  logic             wr_allow,
   input  logic             rd_req,
   output logic [CNT_W-1:0] cnt_nx,
   output logic             empty_q,
   output logic             full_q
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             wr_ok, rd_ok;

   assign wr_ok = wr_req && wr_allow && (cnt_q != DEPTH_C) && !prst;
   assign rd_ok = rd_req && (cnt_q != '0) && !prst;

   always_comb begin
      if (mrst || prst)         cnt_nx = '0;
      else if (wr_ok && !rd_ok) cnt_nx = cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_nx = cnt_q - 1'b1;
      else                      cnt_nx = cnt_q;
   end

   always_ff @(posedge clk) begin
      cnt_q   <= cnt_nx;
      empty_q <= (cnt_nx == '0);
      full_q  <= (cnt_nx == DEPTH_C);
   end

   // R3: occupancy never exceeds capacity
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (mrst)
      cnt_q <= DEPTH_C);

   // R3: a lone write on a full queue is dropped
   p_full_drops_r3: assert property (@(posedge clk) disable iff (mrst)
      (cnt_q == DEPTH_C && wr_req && !rd_req && !prst) |=> cnt_q == DEPTH_C);

   // R8: paired accepted write and read hold the count
   p_pair_hold_r8: assert property (@(posedge clk) disable iff (mrst)
      (wr_ok && rd_ok) |=> $stable(cnt_q));

   // R7: partial reset empties the queue
   p_prst_clear_r7: assert property (@(posedge clk) disable iff (mrst)
      prst |=> (cnt_q == '0) && empty_q);

endmodule

// File: rtl/fifo_thresh_flag.sv
module fifo_thresh_flag #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic [CNT_W-1:0] level_nx,
   input  logic [CNT_W-1:0] thresh_nx,
   output logic             flag_q
);

   always_ff @(posedge clk) begin
      flag_q <= (level_nx <= thresh_nx);
   end

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
   import fifo_flag_pkg::*;
#(
   parameter int DEPTH   = 256,
   parameter int DATA_W  = 36,
   parameter int DEF_LO  = 8,
   parameter int DEF_MID = 16,
   parameter int DEF_HI  = 64
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic [1:0]        preset_sel,
   input  logic              serial_sel,
   input  logic              ser_en,
   input  logic              ser_bit,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic              almost_empty,
   output logic              almost_full,
   output logic              empty,
   output logic              full
);

   localparam int OFS_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   if (DEPTH < 4)                      $error("DEPTH must be at least 4");
   if (DATA_W < OFS_W)                 $error("DATA_W narrower than offset width");
   if (DEF_LO  < 0 || DEF_LO  >= DEPTH) $error("DEF_LO out of range");
   if (DEF_MID < 0 || DEF_MID >= DEPTH) $error("DEF_MID out of range");
   if (DEF_HI  < 0 || DEF_HI  >= DEPTH) $error("DEF_HI out of range");

   logic [OFS_W-1:0] ae_ofs_nx, af_ofs_nx;
   logic             cfg_done;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] lvl  [FLAG_N];
   logic [CNT_W-1:0] thr  [FLAG_N];
   logic             flg  [FLAG_N];

   if (DATA_W > OFS_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
   end

   fifo_ofs_regs #(
      .OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_MID(DEF_MID), .DEF_HI(DEF_HI)
   ) ofs_i (
      .clk(clk), .mrst(mrst), .prst(prst),
      .preset_sel(preset_sel), .serial_sel(serial_sel),
      .ser_en(ser_en), .ser_bit(ser_bit),
      .wr_en(wr_en), .wr_low(wr_data[OFS_W-1:0]),
      .ae_ofs_nx(ae_ofs_nx), .af_ofs_nx(af_ofs_nx), .cfg_done(cfg_done)
   );

   fifo_occ_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) occ_i (
      .clk(clk), .mrst(mrst), .prst(prst),
      .wr_req(wr_en), .wr_allow(cfg_done), .rd_req(rd_en),
      .cnt_nx(cnt_nx), .empty_q(empty), .full_q(full)
   );

   assign lvl[FLAG_AE] = cnt_nx;
   assign thr[FLAG_AE] = CNT_W'(ae_ofs_nx);
   assign lvl[FLAG_AF] = DEPTH_C - cnt_nx;
   assign thr[FLAG_AF] = CNT_W'(af_ofs_nx);

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      fifo_thresh_flag #(.CNT_W(CNT_W)) cmp_i (
         .clk(clk), .level_nx(lvl[g]), .thresh_nx(thr[g]), .flag_q(flg[g])
      );
   end

   assign almost_empty = flg[FLAG_AE];
   assign almost_full  = flg[FLAG_AF];

   // R1: an empty queue is always at or below any almost-empty offset
   p_empty_ae_r1: assert property (@(posedge clk) disable iff (mrst)
      empty |-> almost_empty);

   // R2: a full queue is always at or below any almost-full offset
   p_full_af_r2: assert property (@(posedge clk) disable iff (mrst)
      full |-> almost_full);

   // R3: empty and full never coexist
   p_excl_r3: assert property (@(posedge clk) disable iff (mrst)
      !(empty && full));

endmodule

// File: tb/fifo_level_flags_tb_top.sv
module fifo_level_flags_tb_top;

   localparam int DEPTH = 256;
   localparam int DW    = 36;
   localparam int OW    = 8;

   logic clk = 1'b0;
   logic mrst = 1'b1, prst = 1'b0;
   logic [1:0] preset_sel = 2'b01;
   logic serial_sel = 1'b0, ser_en = 1'b0, ser_bit = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic almost_empty, almost_full, empty, full;

   int checks = 0, failures = 0;
   bit model_valid = 0, finished = 0;

   always #5 clk = ~clk;

   fifo_level_flags #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
      .clk(clk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
      .serial_sel(serial_sel), .ser_en(ser_en), .ser_bit(ser_bit),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .almost_empty(almost_empty), .almost_full(almost_full),
      .empty(empty), .full(full)
   );

   // behavioural reference model
   int m_cnt = 0, m_ae = 0, m_af = 0, m_bits = 0;
   bit m_done = 0, m_ser = 0, m_pc = 0;

   always @(posedge clk) begin
      if (mrst) begin
         m_cnt = 0; m_ser = serial_sel; m_bits = 0; m_pc = 0;
         case (preset_sel)
            2'b01: begin m_ae = 8;  m_af = 8;  m_done = 1; end
            2'b10: begin m_ae = 16; m_af = 16; m_done = 1; end
            2'b11: begin m_ae = 64; m_af = 64; m_done = 1; end
            default: begin m_ae = 0; m_af = 0; m_done = 0; end
         endcase
         model_valid = 1;
      end else if (prst) begin
         m_cnt = 0;
      end else begin
         bit d0;
         bit w, r;
         d0 = m_done;
         if (!m_done) begin
            if (m_ser && ser_en) begin
               if (m_bits < OW) m_ae = m_ae | (int'(ser_bit) << m_bits);
               else             m_af = m_af | (int'(ser_bit) << (m_bits - OW));
               m_bits++;
               if (m_bits == 2*OW) m_done = 1;
            end else if (!m_ser && wr_en) begin
               if (!m_pc) begin m_ae = int'(wr_data[OW-1:0]); m_pc = 1; end
               else       begin m_af = int'(wr_data[OW-1:0]); m_done = 1; end
            end
         end
         w = wr_en && d0 && (m_cnt < DEPTH);
         r = rd_en && (m_cnt > 0);
         m_cnt = m_cnt + int'(w) - int'(r);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // one clock; compare all outputs with the model at the falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      if (model_valid) begin
         chk("R1 almost_empty vs model", int'(almost_empty), int'(m_cnt <= m_ae));
         chk("R2 almost_full vs model",  int'(almost_full),  int'((DEPTH - m_cnt) <= m_af));
         chk("R3 empty vs model",        int'(empty),        int'(m_cnt == 0));
         chk("R3 full vs model",         int'(full),         int'(m_cnt == DEPTH));
      end
   endtask

   task automatic do_mrst(input logic [1:0] sel, input logic smode);
      mrst = 1; preset_sel = sel; serial_sel = smode; tick(); mrst = 0;
   endtask

   task automatic do_wr(input int n, input int val);
      for (int i = 0; i < n; i++) begin
         wr_en = 1; wr_data = DW'(val); tick();
      end
      wr_en = 0;
   endtask

   task automatic do_rd(input int n);
      for (int i = 0; i < n; i++) begin rd_en = 1; tick(); end
      rd_en = 0;
   endtask

   task automatic do_pair(input int n);
      for (int i = 0; i < n; i++) begin wr_en = 1; rd_en = 1; tick(); end
      wr_en = 0; rd_en = 0;
   endtask

   task automatic do_prst();
      prst = 1; tick(); prst = 0;
   endtask

   task automatic shift16(input logic [15:0] v);
      for (int i = 0; i < 16; i++) begin ser_en = 1; ser_bit = v[i]; tick(); end
      ser_en = 0; ser_bit = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R1 watchdog expired act=0 exp=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // preset 8
      do_mrst(2'b01, 1'b0);
      chk("R4 reset ae",    int'(almost_empty), 1);
      chk("R4 reset af",    int'(almost_full),  0);
      chk("R4 reset empty", int'(empty),        1);
      do_wr(8, 1);   chk("R1 ae at count 8", int'(almost_empty), 1);
      do_wr(1, 2);   chk("R1 ae at count 9", int'(almost_empty), 0);
      do_wr(238, 3); chk("R2 af at count 247", int'(almost_full), 0);
      do_wr(1, 4);   chk("R2 af at count 248", int'(almost_full), 1);
      do_wr(8, 5);   chk("R3 full at 256", int'(full), 1);
      do_wr(3, 6);   chk("R3 write on full ignored", int'(full), 1);
      do_rd(1);      chk("R3 one read leaves 255", int'(full), 0);
      do_pair(2);    chk("R8 pair near full holds", int'(full), 0);
      do_wr(1, 7);   chk("R8 count was 255 before write", int'(full), 1);
      do_pair(1);    chk("R8 full: write dropped, read taken", int'(full), 0);
      do_rd(255);    chk("R3 drained", int'(empty), 1);
      do_rd(2);      chk("R3 read on empty ignored", int'(empty), 1);
      do_pair(1);    chk("R8 empty: read dropped, write taken", int'(empty), 0);

      // preset 64, paired traffic and partial reset
      do_mrst(2'b11, 1'b0);
      do_wr(64, 9);  chk("R4 ae at 64", int'(almost_empty), 1);
      do_pair(5);    chk("R8 pair at threshold", int'(almost_empty), 1);
      do_wr(1, 9);   chk("R8 count held at 64", int'(almost_empty), 0);
      do_wr(10, 9);
      prst = 1; wr_en = 1; rd_en = 1; tick(); prst = 0; wr_en = 0; rd_en = 0;
      chk("R7 prst empties", int'(empty), 1);
      do_wr(64, 9);  chk("R7 ae offset kept (64)", int'(almost_empty), 1);
      do_wr(1, 9);   chk("R7 ae offset kept (65)", int'(almost_empty), 0);
      mrst = 1; prst = 1; preset_sel = 2'b10; tick(); mrst = 0; prst = 0;
      chk("R7 mrst wins over prst", int'(empty), 1);
      do_wr(16, 9);  chk("R4 ae at 16", int'(almost_empty), 1);
      do_wr(1, 9);   chk("R4 ae at 17", int'(almost_empty), 0);

      // serial programming: AE=5, AF=3
      do_mrst(2'b00, 1'b1);
      chk("R5 user reset ae", int'(almost_empty), 1);
      do_wr(2, 9);   chk("R5 write before load ignored", int'(empty), 1);
      shift16({8'd3, 8'd5});
      shift16(16'hFFFF);
      do_wr(5, 1);   chk("R5 ae at 5", int'(almost_empty), 1);
      do_wr(1, 1);   chk("R5 ae at 6", int'(almost_empty), 0);
      do_wr(246, 1); chk("R5 af at 252", int'(almost_full), 0);
      do_wr(1, 1);   chk("R5 af at 253", int'(almost_full), 1);

      // parallel programming: AE=20, AF=200
      do_mrst(2'b00, 1'b0);
      do_wr(1, 20);  chk("R6 first load not stored", int'(empty), 1);
      do_wr(1, 200); chk("R6 second load not stored", int'(empty), 1);
      do_wr(20, 7);  chk("R6 ae at 20", int'(almost_empty), 1);
      do_wr(1, 7);   chk("R6 ae at 21", int'(almost_empty), 0);
      do_wr(34, 7);  chk("R6 af at 55", int'(almost_full), 0);
      do_wr(1, 7);   chk("R6 af at 56", int'(almost_full), 1);
      do_prst();
      do_wr(1, 99);  chk("R7 data write after prst stored", int'(empty), 0);
      do_wr(19, 99); chk("R7 ae kept at 20", int'(almost_empty), 1);
      do_wr(1, 99);  chk("R7 ae kept at 21", int'(almost_empty), 0);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule